// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block makes a group of participants wait for one another. Each participant keeps a sense bit of its own and flips it every time it enters a barrier. On entry it gives a one-cycle arrive pulse with the new sense value. The block counts the entries. When the last participant of the group has entered, the block clears the count and sets a shared release bit to the sense of that round. A participant may leave while the release bit equals its own sense.

A release bit that only ever goes set and clear can trap a participant when the barrier is used again at once. Comparing senses avoids this. A fast participant that enters the next round early does not touch the release bit. It waits until the bit flips to its new sense, and a slow participant still sees the earlier flip.

The block keeps its own copy of each participant's sense and shows the result as a per-participant released output. An entry that the block cannot accept is not counted and sets a sticky error flag. This happens when the participant has already entered this round, or when its sense does not match the current round.

Top module: `sense_barrier`

## Requirements
- R1: After reset the release bit is 0, every released output is 1 and the error flag is 0.
- R2: An accepted entry is an arrive pulse from a participant whose released output is 1, given with a sense equal to the inverse of the release bit. It drives that participant's released output to 0 from the next clock edge on.
- R3: Arrive pulses from several participants in the same cycle are all counted in that cycle.
- R4: The Nth accepted entry of a round inverts the release bit on the same clock edge that takes it in. From that edge on, every released output is 1.
- R5: After a release the count starts again from zero, so the next round needs N new accepted entries before the release bit changes.
- R6: A participant that enters the next round before any other participant does leaves the release bit unchanged. Only its own released output drops to 0.
- R7: An arrive pulse from a participant whose released output is 0 sets the error flag and is not counted.
- R8: An arrive pulse with a sense equal to the release bit sets the error flag, is not counted, and leaves that participant's released output at 1.
- R9: The error flag stays at 1 until reset, whatever later traffic occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| arrive | input | N | One-cycle entry pulse per participant |
| sense_in | input | N | Sense value given with each entry |
| release_sense | output | 1 | Shared release bit |
| released | output | N | High while the participant's tracked sense equals the release bit |
| dup_error | output | 1 | Sticky flag for entries that were rejected |

## Verification
Every result is due one clock edge after its stimulus. An arrive pulse sampled on an edge updates the tracked sense, the count, the release bit and the error flag on that same edge. Released is decoded directly from registers, so it is also valid after that edge. The bench applies each pulse at a falling edge, removes it at the next falling edge, and checks the outputs there. That is half a period after the edge that acts on the pulse. Rejected entries are checked at the ports: released stays at 1, and the release bit does not flip early when the remaining participants arrive.

// File: rtl/barrier_pkg.sv
// Package: shared helpers for the barrier unit.
// Assumes at most 32 participants, so a 6-bit count covers every sum.
package barrier_pkg;

    localparam int unsigned MAX_PARTS = 32;
    localparam int unsigned SUM_W     = 6;

    // Count the set bits of a 32-bit vector.
    function automatic logic [SUM_W-1:0] ones32(input logic [MAX_PARTS-1:0] v);
        logic [SUM_W-1:0] acc;
        acc = '0;
        for (int k = 0; k < MAX_PARTS; k++) begin
            acc = acc + SUM_W'(v[k]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/sense_tracker.sv
// Module: sense_tracker
// Keeps one participant's copy of its sense bit. It accepts an entry only while
// the participant is released and its given sense opens a new round. Any other
// entry is flagged as a violation and is not counted.
// Assumes arrive is a one-cycle pulse that is synchronous to clk.
module sense_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic sense_in,
    input  logic release_sense,
    output logic released,
    output logic accept,
    output logic violation
);

    logic local_q;

    // Released while the tracked sense matches the shared release bit.
    always_comb begin
        released  = (local_q == release_sense);
        accept    = arrive && released && (sense_in != release_sense);
        violation = arrive && !accept;
    end

    // Capture the new sense on an accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            local_q <= 1'b0;
        end else if (accept) begin
            local_q <= sense_in;
        end
    end

endmodule

// File: rtl/arrival_counter.sv
// Module: arrival_counter
// Counts accepted entries, several in a cycle if needed. When the round is
// complete it clears the count and inverts the release bit.
// Assumes at most one accepted entry per participant per round, which the
// trackers guarantee, so the count never passes N.
module arrival_counter
    import barrier_pkg::*;
#(
    parameter int unsigned N = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              accept_vec,
    output logic                      release_sense,
    output logic [$clog2(N+1)-1:0]    count
);

    localparam int unsigned CW = $clog2(N+1);

    logic [MAX_PARTS-1:0] padded;
    logic [SUM_W-1:0]     total;
    logic                 round_done;

    // Add this cycle's accepted entries to the running count.
    always_comb begin
        padded     = '0;
        padded[N-1:0] = accept_vec;
        total      = SUM_W'(count) + ones32(padded);
        round_done = (total == SUM_W'(N));
    end

    // Update the count and flip the release bit when the round completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count         <= '0;
            release_sense <= 1'b0;
        end else if (round_done) begin
            count         <= '0;
            release_sense <= ~release_sense;
        end else begin
            count         <= total[CW-1:0];
        end
    end

endmodule

// File: rtl/sticky_flag.sv
// Module: sticky_flag
// Sets on any violation and holds the value until reset.
// Assumes violation is sampled on the clock edge.
module sticky_flag #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] violation_vec,
    output logic         flag
);

    // Latch any violation until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (|violation_vec) begin
            flag <= 1'b1;
        end
    end

endmodule

// File: rtl/sense_barrier.sv
// Module: sense_barrier (top)
// Centralized barrier for N participants using a sense-reversing release bit.
// Assumes N is between 2 and 32 and that arrive pulses last one cycle.
module sense_barrier #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] arrive,
    input  logic [N-1:0] sense_in,
    output logic         release_sense,
    output logic [N-1:0] released,
    output logic         dup_error
);

    localparam int unsigned CW = $clog2(N+1);

    logic [N-1:0]  accept_vec;
    logic [N-1:0]  violation_vec;
    logic [CW-1:0] arrive_cnt;

    // One tracker per participant.
    for (genvar g = 0; g < N; g++) begin : g_part
        sense_tracker u_trk (
            .clk          (clk),
            .rst_n        (rst_n),
            .arrive       (arrive[g]),
            .sense_in     (sense_in[g]),
            .release_sense(release_sense),
            .released     (released[g]),
            .accept       (accept_vec[g]),
            .violation    (violation_vec[g])
        );
    end

    arrival_counter #(.N(N)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .accept_vec   (accept_vec),
        .release_sense(release_sense),
        .count        (arrive_cnt)
    );

    sticky_flag #(.N(N)) u_err (
        .clk          (clk),
        .rst_n        (rst_n),
        .violation_vec(violation_vec),
        .flag         (dup_error)
    );

endmodule

// File: rtl/barrier_checker.sv
// Module: barrier_checker
// Property checks for sense_barrier. It is attached to every instance by the
// bind statement below.
module barrier_checker #(
    parameter int unsigned N = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N-1:0]           arrive,
    input logic [N-1:0]           sense_in,
    input logic                   release_sense,
    input logic [N-1:0]           released,
    input logic                   dup_error,
    input logic [$clog2(N+1)-1:0] count
);

    AST_RESET_STATE: assert property (@(posedge clk) !rst_n |=> (!release_sense && (&released) && !dup_error)); // R1
    AST_DROP_NEEDS_ARRIVE: assert property (@(posedge clk) disable iff (!rst_n) ((~released & $past(released) & ~$past(arrive)) == '0)); // R2
    AST_FLIP_RELEASES_ALL: assert property (@(posedge clk) disable iff (!rst_n) !$stable(release_sense) |-> (&released)); // R4
    AST_FLIP_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n) !$stable(release_sense) |-> (count == '0)); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) (32'(count) < N)); // R5
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(dup_error) |-> $past(|(arrive & ~(released & (sense_in ^ {N{release_sense}}))))); // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) $past(dup_error) |-> dup_error); // R9

endmodule

bind sense_barrier barrier_checker #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arrive       (arrive),
    .sense_in     (sense_in),
    .release_sense(release_sense),
    .released     (released),
    .dup_error    (dup_error),
    .count        (arrive_cnt)
);

// File: tb/sense_barrier_bench.sv
// Directed bench for sense_barrier with four participants.
module sense_barrier_bench;

    localparam int unsigned N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] arrive = '0;
    logic [N-1:0] sense_in = '0;
    logic         release_sense;
    logic [N-1:0] released;
    logic         dup_error;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    sense_barrier #(.N(N)) u_sense_barrier (
        .clk(clk), .rst_n(rst_n), .arrive(arrive), .sense_in(sense_in),
        .release_sense(release_sense), .released(released), .dup_error(dup_error)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Hold one pulse for a single cycle; the outputs are then due at the next falling edge.
    task automatic pulse(input logic [N-1:0] m, input logic [N-1:0] s);
        @(negedge clk);
        arrive   = m;
        sense_in = s;
        @(negedge clk);
        arrive   = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 release", int'(release_sense), 0);
        check("R1 released", int'(released), 4'hF);
        check("R1 error", int'(dup_error), 0);
    endtask

    task automatic t_basic();
        pulse(4'b0001, 4'b1111);
        check("R2 released", int'(released), 4'b1110);
        check("R2 release", int'(release_sense), 0);
        pulse(4'b0010, 4'b1111);
        check("R2 released", int'(released), 4'b1100);
        pulse(4'b1100, 4'b1111);
        check("R3 R4 release", int'(release_sense), 1);
        check("R4 released", int'(released), 4'hF);
    endtask

    task automatic t_reuse();
        pulse(4'b0001, 4'b0000);
        check("R6 release", int'(release_sense), 1);
        check("R6 released", int'(released), 4'b1110);
        pulse(4'b0010, 4'b0000);
        pulse(4'b0100, 4'b0000);
        check("R5 release", int'(release_sense), 1);
        check("R5 released", int'(released), 4'b1000);
        pulse(4'b1000, 4'b0000);
        check("R5 R4 release", int'(release_sense), 0);
        check("R4 released", int'(released), 4'hF);
        check("R7 no error", int'(dup_error), 0);
    endtask

    task automatic t_all_at_once();
        pulse(4'b1111, 4'b1111);
        check("R3 release", int'(release_sense), 1);
        check("R3 released", int'(released), 4'hF);
    endtask

    task automatic t_wrong_sense();
        pulse(4'b0001, 4'b0001);
        check("R8 error", int'(dup_error), 1);
        check("R8 released", int'(released), 4'hF);
        pulse(4'b1110, 4'b0000);
        check("R8 release", int'(release_sense), 1);
        pulse(4'b0001, 4'b0000);
        check("R8 R4 release", int'(release_sense), 0);
        check("R9 error", int'(dup_error), 1);
    endtask

    task automatic t_duplicate();
        do_reset();
        pulse(4'b0001, 4'b1111);
        pulse(4'b0001, 4'b1111);
        check("R7 error", int'(dup_error), 1);
        check("R7 released", int'(released), 4'b1110);
        pulse(4'b0110, 4'b1111);
        check("R7 release", int'(release_sense), 0);
        pulse(4'b1000, 4'b1111);
        check("R7 R4 release", int'(release_sense), 1);
        check("R9 error", int'(dup_error), 1);
        do_reset();
        check("R1 R9 error", int'(dup_error), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_reuse();
        t_all_at_once();
        t_wrong_sense();
        t_duplicate();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule